// File: doc/BRIEF.md
# Video Byte-Pair Packer with Field Routing

This block sits between an 8-bit video sample stream and a 16-bit parallel receive port. The port moves a full 16-bit word on every transfer. A lone 8-bit sample would waste the upper byte as padding, so the block joins each pair of consecutive samples into one word. Every outgoing word is tagged with the field parity (odd or even) of its source data. It also carries a destination address, which is a per-field base plus a running word offset. That lets the downstream store keep the two fields in separate regions.

A mode input can restrict the output to a single field parity. Samples of the rejected parity are discarded before packing. Line and field boundaries arrive as sideband flags on the first sample of a line or field. If a line ends on an odd sample count, the leftover byte is flushed as a zero-padded word. The output is a single registered slot with a valid/ready handshake. A word that completes while the slot is stalled is discarded and recorded.

Top module: `byte_pair_packer`

## Requirements
- R1: Two accepted samples in a row within one line form one word, with the earlier sample in bits [7:0] and the later sample in bits [15:8]. The word appears on the output one clock after the second sample.
- R2: The word address is the base of the word's field plus a word offset, taken modulo 2^ADDR_W. The offset is zero-extended and counts up by one for each word emitted, wrapping modulo 2^OFFSET_W. `baseOdd` is the base when `outOdd`=1, and `baseEven` is the base when `outOdd`=0.
- R3: A word may complete (as a pair or as a flush) while `outValid`=1 and `outReady`=0. In that case the word is discarded, its bytes are not kept, the offset does not advance, and `overflow` becomes 1 and stays 1 until reset.
- R4: A sample flagged with `lineStart` or `fieldStart` may arrive while one byte is still waiting. The waiting byte is then emitted as a word with bits [15:8]=0, and `padErr` becomes 1 and stays 1 until reset. The flagged sample starts a new pair.
- R5: `fieldMode` selects which samples are kept: 0 or 3 keeps both parities, 1 keeps only odd-field samples, and 2 keeps only even-field samples.
- R6: While `outValid`=1 and `outReady`=0, `outValid`, `outData`, `outAddr` and `outOdd` hold their values.
- R7: After reset, `outValid`, `overflow` and `padErr` are 0.
- R8: A rejected sample (filtered by R5, or `inValid`=0) creates no waiting byte, emits no word and does not advance the offset.
- R9: `fieldOdd` is sampled only on a valid sample with `fieldStart`=1. That sample resets the word offset to 0 for the new field. The field parity it sets applies to that sample and to every later sample until the next field start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Sample strobe |
| inData | input | DATA_W | Video sample |
| lineStart | input | 1 | Sample is the first of a line |
| fieldStart | input | 1 | Sample is the first of a field (also starts a line) |
| fieldOdd | input | 1 | Parity of the field begun by `fieldStart` |
| fieldMode | input | 2 | Parity filter select |
| baseOdd | input | ADDR_W | Address base for odd-field words |
| baseEven | input | ADDR_W | Address base for even-field words |
| outReady | input | 1 | Consumer accepts the current word |
| outValid | output | 1 | Output slot holds a word |
| outData | output | 2*DATA_W | Packed word |
| outOdd | output | 1 | Field parity of the word |
| outAddr | output | ADDR_W | Destination address of the word |
| overflow | output | 1 | Sticky: a word was discarded on stall |
| padErr | output | 1 | Sticky: a zero-padded flush occurred |

## Verification
The bench builds the block with OFFSET_W=4 and keeps the 16-bit address and 8-bit sample widths. With a 4-bit offset, fields of up to six lines of random odd and even lengths wrap the offset inside a field, so the modulo rule of R2 is exercised. The bench repeats its random traffic under each of the four filter settings. Because `outReady` is dropped at random, stalls coincide with both pair completions and line-end flushes, which exercises the discard path of R3 together with R4.

// File: rtl/packer_pkg.sv
package packer_pkg;

  typedef enum logic [1:0] {
    SEL_BOTH = 2'd0,
    SEL_ODD  = 2'd1,
    SEL_EVEN = 2'd2,
    SEL_ANY  = 2'd3
  } fieldSel_e;

  typedef struct packed {
    logic loadLow;
    logic emitPair;
    logic emitFlush;
    logic dropWord;
    logic wordOdd;
    logic restartField;
  } packCmd_t;

endpackage

// File: rtl/pack_ctrl.sv
module pack_ctrl
  import packer_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic       lineStart,
  input  logic       fieldStart,
  input  logic       fieldOdd,
  input  logic [1:0] fieldMode,
  input  logic       outValid,
  input  logic       outReady,
  output packCmd_t   cmd,
  output logic       overflow,
  output logic       padErr
);

  logic pend, pendNext;
  logic curOdd;
  logic lineEv, effOdd, pass, accept;
  logic flushNow, pairNow, slotFree;

  always_comb begin
    lineEv = inValid && (lineStart || fieldStart);
    effOdd = fieldStart ? fieldOdd : curOdd;
    case (fieldSel_e'(fieldMode))
      SEL_ODD:  pass = effOdd;
      SEL_EVEN: pass = !effOdd;
      default:  pass = 1'b1;
    endcase
    accept   = inValid && pass;
    flushNow = lineEv && pend;
    pairNow  = accept && pend && !lineEv;
    slotFree = !outValid || outReady;

    cmd.emitFlush    = flushNow && slotFree;
    cmd.emitPair     = pairNow && slotFree;
    cmd.dropWord     = (flushNow || pairNow) && !slotFree;
    cmd.loadLow      = accept && (lineEv || !pend);
    cmd.wordOdd      = curOdd;
    cmd.restartField = inValid && fieldStart;

    if (lineEv)       pendNext = accept;
    else if (pairNow) pendNext = 1'b0;
    else if (accept)  pendNext = 1'b1;
    else              pendNext = pend;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pend     <= 1'b0;
      curOdd   <= 1'b0;
      overflow <= 1'b0;
      padErr   <= 1'b0;
    end else begin
      pend <= pendNext;
      if (cmd.restartField) curOdd <= fieldOdd;
      if (cmd.dropWord) overflow <= 1'b1;
      if (flushNow) padErr <= 1'b1;
    end
  end

endmodule

// File: rtl/pack_data.sv
module pack_data
  import packer_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int ADDR_W   = 16,
  parameter int OFFSET_W = 12,
  localparam int WORD_W  = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  packCmd_t          cmd,
  input  logic [DATA_W-1:0] inData,
  input  logic              outReady,
  input  logic [ADDR_W-1:0] baseOdd,
  input  logic [ADDR_W-1:0] baseEven,
  output logic              outValid,
  output logic [WORD_W-1:0] outData,
  output logic              outOdd,
  output logic [ADDR_W-1:0] outAddr
);

  logic [DATA_W-1:0]   lowByte;
  logic [OFFSET_W-1:0] offset;
  logic [ADDR_W-1:0]   offExt;
  logic [ADDR_W-1:0]   wordAddr;
  logic [WORD_W-1:0]   wordData;
  logic                emit;

  generate
    if (OFFSET_W >= ADDR_W) begin : gTrunc
      assign offExt = offset[ADDR_W-1:0];
    end else begin : gExtend
      assign offExt = {{(ADDR_W-OFFSET_W){1'b0}}, offset};
    end
  endgenerate

  always_comb begin
    emit     = cmd.emitPair || cmd.emitFlush;
    wordAddr = (cmd.wordOdd ? baseOdd : baseEven) + offExt;
    wordData = cmd.emitFlush ? {{DATA_W{1'b0}}, lowByte} : {inData, lowByte};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lowByte  <= '0;
      offset   <= '0;
      outValid <= 1'b0;
      outData  <= '0;
      outOdd   <= 1'b0;
      outAddr  <= '0;
    end else begin
      if (cmd.loadLow) lowByte <= inData;
      if (cmd.restartField) offset <= '0;
      else if (emit) offset <= offset + 1'b1;
      if (emit) begin
        outValid <= 1'b1;
        outData  <= wordData;
        outOdd   <= cmd.wordOdd;
        outAddr  <= wordAddr;
      end else if (outReady) begin
        outValid <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/byte_pair_packer.sv
module byte_pair_packer
  import packer_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int ADDR_W   = 16,
  parameter int OFFSET_W = 12
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  inValid,
  input  logic [DATA_W-1:0]     inData,
  input  logic                  lineStart,
  input  logic                  fieldStart,
  input  logic                  fieldOdd,
  input  logic [1:0]            fieldMode,
  input  logic [ADDR_W-1:0]     baseOdd,
  input  logic [ADDR_W-1:0]     baseEven,
  input  logic                  outReady,
  output logic                  outValid,
  output logic [2*DATA_W-1:0]   outData,
  output logic                  outOdd,
  output logic [ADDR_W-1:0]     outAddr,
  output logic                  overflow,
  output logic                  padErr
);

  packCmd_t cmd;

  pack_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .lineStart(lineStart),
    .fieldStart(fieldStart), .fieldOdd(fieldOdd), .fieldMode(fieldMode),
    .outValid(outValid), .outReady(outReady), .cmd(cmd),
    .overflow(overflow), .padErr(padErr)
  );

  pack_data #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .OFFSET_W(OFFSET_W)) uData (
    .clk(clk), .rstN(rstN), .cmd(cmd), .inData(inData), .outReady(outReady),
    .baseOdd(baseOdd), .baseEven(baseEven), .outValid(outValid),
    .outData(outData), .outOdd(outOdd), .outAddr(outAddr)
  );

endmodule

// File: rtl/pack_checker.sv
module pack_checker #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 16
) (
  input logic                clk,
  input logic                rstN,
  input logic                inValid,
  input logic                lineStart,
  input logic                fieldStart,
  input logic                outReady,
  input logic                outValid,
  input logic [2*DATA_W-1:0] outData,
  input logic                outOdd,
  input logic [ADDR_W-1:0]   outAddr,
  input logic                overflow,
  input logic                padErr
);

  assert_hold_valid_R6: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> outValid);

  assert_hold_word_R6: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> $stable(outData) && $stable(outAddr) && $stable(outOdd));

  assert_overflow_sticky_R3: assert property (@(posedge clk) disable iff (!rstN)
    overflow |=> overflow);

  assert_overflow_cause_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overflow) |-> $past(outValid && !outReady && inValid));

  assert_pad_sticky_R4: assert property (@(posedge clk) disable iff (!rstN)
    padErr |=> padErr);

  assert_pad_cause_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(padErr) |-> $past(inValid && (lineStart || fieldStart)));

endmodule

bind byte_pair_packer pack_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) uChk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .lineStart(lineStart),
  .fieldStart(fieldStart), .outReady(outReady), .outValid(outValid),
  .outData(outData), .outOdd(outOdd), .outAddr(outAddr),
  .overflow(overflow), .padErr(padErr)
);

// File: tb/tb_byte_pair_packer.sv
`timescale 1ns/1ps
module tb_byte_pair_packer;

  localparam int DW = 8;
  localparam int AW = 16;
  localparam int OW = 4;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          inValid = 1'b0;
  logic [DW-1:0] inData = '0;
  logic          lineStart = 1'b0;
  logic          fieldStart = 1'b0;
  logic          fieldOdd = 1'b0;
  logic [1:0]    fieldMode = 2'd0;
  logic [AW-1:0] baseOdd = 16'h4000;
  logic [AW-1:0] baseEven = 16'h1000;
  logic          outReady = 1'b1;
  logic          outValid;
  logic [2*DW-1:0] outData;
  logic          outOdd;
  logic [AW-1:0] outAddr;
  logic          overflow;
  logic          padErr;

  always #4 clk = ~clk;

  byte_pair_packer #(.DATA_W(DW), .ADDR_W(AW), .OFFSET_W(OW)) dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inData(inData),
    .lineStart(lineStart), .fieldStart(fieldStart), .fieldOdd(fieldOdd),
    .fieldMode(fieldMode), .baseOdd(baseOdd), .baseEven(baseEven),
    .outReady(outReady), .outValid(outValid), .outData(outData),
    .outOdd(outOdd), .outAddr(outAddr), .overflow(overflow), .padErr(padErr)
  );

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  // expected state, current and next
  typedef struct {
    bit pend; bit [7:0] low; bit odd; int off;
    bit val; bit [15:0] data; bit [15:0] addr; bit wodd;
    bit ovf; bit pad;
  } model_t;
  model_t m, nx;

  function automatic model_t resetModel();
    model_t r;
    r.pend = 0; r.low = 0; r.odd = 0; r.off = 0;
    r.val = 0; r.data = 0; r.addr = 0; r.wodd = 0; r.ovf = 0; r.pad = 0;
    return r;
  endfunction

  function automatic bit keepSample(bit [1:0] mode, bit par);
    if (mode == 2'd1) return par;
    if (mode == 2'd2) return !par;
    return 1'b1;
  endfunction

  function automatic model_t predict(model_t s, bit v, bit [7:0] d, bit ls, bit fs,
                                     bit fo, bit [1:0] mode, bit rdy);
    model_t n = s;
    bit lineEv = v && (ls || fs);
    bit par = fs ? fo : s.odd;
    bit acc = v && keepSample(mode, par);
    bit fl = lineEv && s.pend;
    bit pr = acc && s.pend && !lineEv;
    bit free = !s.val || rdy;
    if ((fl || pr) && free) begin
      n.val  = 1;
      n.data = fl ? {8'h00, s.low} : {d, s.low};
      n.addr = (s.odd ? baseOdd : baseEven) + 16'(s.off);
      n.wodd = s.odd;
      n.off  = (s.off + 1) % (1 << OW);
    end else if (rdy) n.val = 0;
    if ((fl || pr) && !free) n.ovf = 1;
    if (fl) n.pad = 1;
    if (v && fs) begin n.odd = fo; n.off = 0; end
    if (acc && (lineEv || !s.pend)) n.low = d;
    if (lineEv) n.pend = acc;
    else if (pr) n.pend = 0;
    else if (acc) n.pend = 1;
    return n;
  endfunction

  task automatic chk(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compareModel();
    chk(outValid == m.val, "R1 R6 valid", outValid, m.val);
    if (m.val && outValid) begin
      chk(outData == m.data, "R1 R4 data", outData, m.data);
      chk(outAddr == m.addr, "R2 R9 addr", outAddr, m.addr);
      chk(outOdd == m.wodd, "R9 R5 parity", outOdd, m.wodd);
    end
    chk(overflow == m.ovf, "R3 overflow", overflow, m.ovf);
    chk(padErr == m.pad, "R4 padErr", padErr, m.pad);
  endtask

  task automatic step(bit v, bit [7:0] d, bit ls, bit fs, bit fo, bit rdy);
    @(negedge clk);
    m = nx;
    compareModel();
    inValid = v; inData = d; lineStart = ls; fieldStart = fs;
    fieldOdd = fo; outReady = rdy;
    nx = predict(m, v, d, ls, fs, fo, fieldMode, rdy);
  endtask

  task automatic doReset(bit [1:0] mode);
    @(negedge clk);
    rstN = 0; inValid = 0; lineStart = 0; fieldStart = 0; outReady = 1;
    fieldMode = mode;
    m = resetModel(); nx = resetModel();
    repeat (2) @(negedge clk);
    rstN = 1;
  endtask

  initial begin
    #1600000;
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(1234));
    doReset(2'd0);
    // R7 reset state
    chk(outValid == 0, "R7 outValid", outValid, 0);
    chk(overflow == 0, "R7 overflow", overflow, 0);
    chk(padErr == 0, "R7 padErr", padErr, 0);

    // R1/R2/R9 directed pair in an odd field
    step(1, 8'h11, 1, 1, 1, 1);
    step(1, 8'h22, 0, 0, 1, 1);
    step(0, 8'h00, 0, 0, 0, 1);
    step(0, 8'h00, 0, 0, 0, 1);
    chk(outData == 16'h2211, "R1 byte order", outData, 16'h2211);
    chk(outAddr == 16'h4000, "R2 odd base", outAddr, 16'h4000);
    chk(outOdd == 1, "R9 parity", outOdd, 1);

    // R4 flush with zero pad
    step(1, 8'h33, 1, 0, 0, 1);
    step(1, 8'h44, 1, 0, 0, 1);
    step(0, 8'h00, 0, 0, 0, 1);
    chk(outData == 16'h0033, "R4 flush pad", outData, 16'h0033);
    chk(padErr == 1, "R4 sticky", padErr, 1);

    // R3 stall: first pair held, second dropped
    doReset(2'd0);
    step(1, 8'hA1, 1, 1, 0, 0);
    step(1, 8'hA2, 0, 0, 0, 0);
    step(1, 8'hA3, 0, 0, 0, 0);
    step(1, 8'hA4, 0, 0, 0, 0);
    step(0, 8'h00, 0, 0, 0, 0);
    chk(outData == 16'hA2A1, "R3 R6 held word", outData, 16'hA2A1);
    chk(outAddr == 16'h1000, "R2 even base", outAddr, 16'h1000);
    chk(overflow == 1, "R3 overflow set", overflow, 1);

    // R5/R8 directed: even-only mode ignores an odd field
    doReset(2'd2);
    step(1, 8'h55, 1, 1, 1, 1);
    step(1, 8'h66, 0, 0, 1, 1);
    step(0, 8'h00, 0, 0, 0, 1);
    step(0, 8'h00, 0, 0, 0, 1);
    chk(outValid == 0, "R5 R8 filtered", outValid, 0);
    step(1, 8'h77, 1, 1, 0, 1);
    step(1, 8'h88, 0, 0, 0, 1);
    step(0, 8'h00, 0, 0, 0, 1);
    step(0, 8'h00, 0, 0, 0, 1);
    chk(outData == 16'h8877 && outAddr == 16'h1000, "R8 no residue", outData, 16'h8877);

    // random traffic in every filter mode
    for (int seg = 0; seg < 4; seg++) begin
      doReset(2'(seg));
      for (int f = 0; f < 6; f++) begin
        bit par = bit'((f + seg) % 2);
        for (int ln = 0; ln < 6; ln++) begin
          int len = 1 + int'($urandom % 7);
          for (int b = 0; b < len; b++) begin
            while (($urandom % 5) == 0)
              step(0, 8'($urandom), 0, 0, par, ($urandom % 4) != 0);
            step(1, 8'($urandom), b == 0, (b == 0) && (ln == 0), par,
                 ($urandom % 4) != 0);
          end
        end
      end
      repeat (4) step(0, 8'h00, 0, 0, 0, 1);
    end

    finished = 1;
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule